// File: doc/BRIEF.md
# Staggered Multi-Channel Start Sequencer

The block starts a group of identical interpolating channel engines that share one output stream, so that their input sample requests fall into an even rotation. One start event reaches every channel at once. It can come from an external sync pin, from a software start strobe, or from both, as the enable mask selects. Each channel holds off for its own programmed number of clocks and then begins to run. A running channel raises a one-cycle request pulse every `INTERP_L` clocks. Each channel accepts one sample out of every `NUM_CH`.

Software programs the same configuration into every channel except the hold-off value. Consecutive hold-offs differ by `INTERP_L/NUM_CH`. With these values the requests from the channels fall in distinct slots, `INTERP_L/NUM_CH` clocks apart. An incoming sample is steered only to the channel whose request is high in that cycle. When the channels sit in an upstream device of a cascade, a one-bit input adds one extra clock to every hold-off. A software stop strobe halts all channels.

Top module: `stagger_start_seq`

## Requirements
- R1: After reset `run_o`, `req_o`, `ch_valid_o` and `collide_o` are all zero.
- R2: `start_sel_i[0]` enables the sync pin and `start_sel_i[1]` enables `sw_start_i`. A source whose bit is clear is ignored. In the default edge mode only a rising edge on `sync_pin_i` starts the channels, so a pin held high produces exactly one start.
- R3: A start event is sampled at clock edge E. Channel i has hold-off value h taken from `hold_i[i*HOLD_W +: HOLD_W]`. Its `run_o[i]` and first `req_o[i]` pulse appear right after edge E+h. A value of 0 acts as 1.
- R4: While `cascade_up_i` is 1, every channel's start is one clock later than R3 gives.
- R5: A running channel pulses `req_o[i]` for one cycle every `INTERP_L` clocks. With hold-offs spaced by `INTERP_L/NUM_CH`, the channels' requests fall in distinct cycles, evenly spaced.
- R6: A start event that arrives while channels are counting or running clears every `run_o` bit and reloads all counters from their programmed values. Timing then restarts from the new event.
- R7: `sw_stop_i` clears all `run_o` bits and pending hold-offs at the next edge. When it coincides with a start event, the stop wins.
- R8: In a cycle where exactly one `req_o` bit i is high, `din_i` is captured into `ch_data_o[i*DATA_W +: DATA_W]`. `ch_valid_o[i]` then pulses in the following cycle. The data of the other channels is left unchanged.
- R9: In a cycle where two or more `req_o` bits are high, no channel captures data and `collide_o` is set. `collide_o` stays set until the next start event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_sel_i | input | 2 | Start source enables: bit0 sync pin, bit1 software strobe |
| sync_pin_i | input | 1 | External sync input |
| sw_start_i | input | 1 | Software start strobe |
| sw_stop_i | input | 1 | Software stop strobe |
| cascade_up_i | input | 1 | Adds one clock to every hold-off (upstream device of a cascade) |
| hold_i | input | NUM_CH*HOLD_W | Per-channel hold-off values |
| din_i | input | DATA_W | Input sample |
| run_o | output | NUM_CH | Channel running flags |
| req_o | output | NUM_CH | Per-channel sample request pulses |
| ch_data_o | output | NUM_CH*DATA_W | Last sample delivered to each channel |
| ch_valid_o | output | NUM_CH | Per-channel delivery pulse |
| collide_o | output | 1 | Sticky flag for simultaneous requests |

## Verification
The bench drives each start with a stepping data ramp and compares every cycle of the request vector, as well as the delivered data, against a timing model. The evenly spaced hold-offs 1/21/41/61 show whether the rotation keeps its 20-cycle slot spacing and its 80-cycle period. A zero hold-off with the cascade bit set separates the clamping rule from the one-clock cascade shift. Equal hold-offs force a collision, which shows whether delivery is suppressed and whether the flag stays set. Further patterns cover a long high level on the pin, a software strobe while that source is masked, a restart in the middle of a count, and a stop issued together with a start. Each of these tells apart edge and level start handling, source masking, reloading of the counters, and the priority between stop and start.

// File: rtl/stsq_pkg.sv
package stsq_pkg;

   // Clock spacing between neighbouring channels' request slots
   function automatic int unsigned slot_gap(input int unsigned l, input int unsigned n);
      return l / n;
   endfunction

   // Encoding of the start source enable mask
   localparam int unsigned SRC_PIN_BIT = 0;
   localparam int unsigned SRC_SW_BIT  = 1;

endpackage

// File: rtl/stsq_holdoff.sv
module stsq_holdoff #(
   parameter int unsigned HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              extra_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic              run_o
);
   localparam int unsigned CW = HOLD_W + 1;

   logic [CW-1:0] cnt_q;
   logic          armed_q;
   logic          run_q;
   logic [CW-1:0] load_val;

   // A zero hold-off acts as one; the cascade bit adds one more clock
   always_comb begin
      load_val = {1'b0, hold_i};
      if (hold_i == '0) load_val = CW'(1);
      load_val = load_val + CW'(extra_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         run_q   <= 1'b0;
      end else if (stop_i) begin
         armed_q <= 1'b0;
         run_q   <= 1'b0;
      end else if (start_i) begin
         cnt_q   <= load_val;
         armed_q <= 1'b1;
         run_q   <= 1'b0;
      end else if (armed_q) begin
         if (cnt_q <= CW'(1)) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            run_q   <= 1'b1;
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end

   assign run_o = run_q;

   // A channel only begins running at the end of a countdown
   assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(armed_q));

   // An armed counter never counts below zero
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (cnt_q != '0));

endmodule

// File: rtl/stsq_reqgen.sv
module stsq_reqgen #(
   parameter int unsigned INTERP_L = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic req_o
);
   localparam int unsigned PW = (INTERP_L > 1) ? $clog2(INTERP_L) : 1;

   logic [PW-1:0] ph_q;

   generate
      if (INTERP_L == 1) begin : g_every
         // One request per clock; no phase counter needed
         always_ff @(posedge clk) begin
            if (!rst_n) ph_q <= '0;
            else        ph_q <= '0;
         end
         assign req_o = run_i;
      end else begin : g_count
         always_ff @(posedge clk) begin
            if (!rst_n || !run_i)            ph_q <= '0;
            else if (ph_q == PW'(INTERP_L-1)) ph_q <= '0;
            else                              ph_q <= ph_q + PW'(1);
         end
         assign req_o = run_i && (ph_q == '0);

         // A request is always a single-cycle pulse
         assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            req_o |=> !req_o);
      end
   endgenerate

endmodule

// File: rtl/stsq_steer.sv
module stsq_steer #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [NUM_CH-1:0]        req_i,
   input  logic [DATA_W-1:0]        din_i,
   output logic [NUM_CH*DATA_W-1:0] data_o,
   output logic [NUM_CH-1:0]        valid_o,
   output logic                     collide_o
);
   logic multi;
   logic single;
   logic [NUM_CH-1:0] valid_q;
   logic              err_q;

   assign multi  = ($countones(req_i) > 1);
   assign single = (req_i != '0) && !multi;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
         logic [DATA_W-1:0] d_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                d_q <= '0;
            else if (req_i[c] && single) d_q <= din_i;
         end
         assign data_o[c*DATA_W +: DATA_W] = d_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         err_q   <= 1'b0;
      end else begin
         valid_q <= single ? req_i : '0;
         if (start_i)    err_q <= 1'b0;
         else if (multi) err_q <= 1'b1;
      end
   end

   assign valid_o   = valid_q;
   assign collide_o = err_q;

   assert_one_delivery_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(valid_q));

   assert_collide_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(req_i) > 1) |=> (valid_q == '0) && err_q);

   assert_collide_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !start_i) |=> err_q);

endmodule

// File: rtl/stagger_start_seq.sv
module stagger_start_seq
   import stsq_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned INTERP_L  = 80,
   parameter int unsigned HOLD_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter bit          SYNC_EDGE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               start_sel_i,
   input  logic                     sync_pin_i,
   input  logic                     sw_start_i,
   input  logic                     sw_stop_i,
   input  logic                     cascade_up_i,
   input  logic [NUM_CH*HOLD_W-1:0] hold_i,
   input  logic [DATA_W-1:0]        din_i,
   output logic [NUM_CH-1:0]        run_o,
   output logic [NUM_CH-1:0]        req_o,
   output logic [NUM_CH*DATA_W-1:0] ch_data_o,
   output logic [NUM_CH-1:0]        ch_valid_o,
   output logic                     collide_o
);
   localparam int unsigned GAP = slot_gap(INTERP_L, NUM_CH);

   // Elaboration-time parameter checks
   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("NUM_CH must be at least 2");
      end
      if (GAP * NUM_CH != INTERP_L) begin : g_bad_l
         $error("INTERP_L must be a multiple of NUM_CH");
      end
      if (HOLD_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("HOLD_W and DATA_W must be positive");
      end
   endgenerate

   // Start source selection
   logic pin_evt;
   logic start_evt;

   generate
      if (SYNC_EDGE) begin : g_pin_edge
         logic pin_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= sync_pin_i;
         end
         assign pin_evt = sync_pin_i && !pin_q;
      end else begin : g_pin_level
         assign pin_evt = sync_pin_i;
      end
   endgenerate

   assign start_evt = (pin_evt && start_sel_i[SRC_PIN_BIT]) ||
                      (sw_start_i && start_sel_i[SRC_SW_BIT]);

   // Per-channel hold-off and request generation
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         stsq_holdoff #(.HOLD_W(HOLD_W)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_evt),
            .stop_i  (sw_stop_i),
            .extra_i (cascade_up_i),
            .hold_i  (hold_i[c*HOLD_W +: HOLD_W]),
            .run_o   (run_o[c])
         );
         stsq_reqgen #(.INTERP_L(INTERP_L)) u_req (
            .clk   (clk),
            .rst_n (rst_n),
            .run_i (run_o[c]),
            .req_o (req_o[c])
         );
      end
   endgenerate

   stsq_steer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_steer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_evt),
      .req_i     (req_o),
      .din_i     (din_i),
      .data_o    (ch_data_o),
      .valid_o   (ch_valid_o),
      .collide_o (collide_o)
   );

   assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_stop_i |=> (run_o == '0));

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (run_o == '0));

   assert_req_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_o & ~run_o) == '0));

endmodule

// File: tb/stagger_start_seq_bench.sv
`timescale 1ns/1ps
module stagger_start_seq_bench;
   localparam int N  = 4;
   localparam int L  = 80;
   localparam int HW = 8;
   localparam int DW = 32;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        start_sel;
   logic              sync_pin, sw_start, sw_stop, cascade;
   logic [N*HW-1:0]   hold;
   logic [DW-1:0]     din;
   logic [N-1:0]      run, req, valid;
   logic [N*DW-1:0]   cdata;
   logic              collide;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;
   int hold_b [N];
   int casc_b;

   always #2.5 clk = ~clk;

   stagger_start_seq u_stagger_start_seq (
      .clk(clk), .rst_n(rst_n), .start_sel_i(start_sel), .sync_pin_i(sync_pin),
      .sw_start_i(sw_start), .sw_stop_i(sw_stop), .cascade_up_i(cascade),
      .hold_i(hold), .din_i(din), .run_o(run), .req_o(req),
      .ch_data_o(cdata), .ch_valid_o(valid), .collide_o(collide));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic set_holds(input int h0, input int h1, input int h2, input int h3, input int c);
      hold_b[0] = h0; hold_b[1] = h1; hold_b[2] = h2; hold_b[3] = h3; casc_b = c;
      for (int i = 0; i < N; i++) hold[i*HW +: HW] = HW'(hold_b[i]);
      cascade = c[0];
   endtask

   function automatic bit exp_req(input int ch, input int k);
      int e;
      e = ((hold_b[ch] == 0) ? 1 : hold_b[ch]) + casc_b;
      return (k >= e) && (((k - e) % L) == 0);
   endfunction

   function automatic logic [N-1:0] exp_vec(input int k);
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = exp_req(i, k);
      return v;
   endfunction

   // Called at a negedge: drives a software start through the edge that follows
   task automatic fire_sw(input bit with_stop);
      sw_start = 1'b1; sw_stop = with_stop;
      @(negedge clk);
      sw_start = 1'b0; sw_stop = 1'b0;
   endtask

   // Now at k=0 (just after the start edge). Checks k = 0..K.
   task automatic window(input int K, input string tag, input int pin_drop);
      logic [N-1:0] ev;
      logic [N-1:0] pv;
      pv = '0;
      for (int k = 0; k <= K; k++) begin
         if (k > 0) @(negedge clk);
         if (k == pin_drop) sync_pin = 1'b0;
         ev = exp_vec(k);
         chk(req == ev, {tag, " req"}, 64'(req), 64'(ev));
         if (k > 0) begin
            logic [N-1:0] vexp;
            vexp = ($countones(pv) == 1) ? pv : '0;
            chk(valid == vexp, "R8 valid", 64'(valid), 64'(vexp));
            for (int i = 0; i < N; i++)
               if (vexp[i])
                  chk(cdata[i*DW +: DW] == DW'(32'hD000_0000 + k - 1), "R8 data",
                      64'(cdata[i*DW +: DW]), 64'(32'hD000_0000 + k - 1));
         end
         din = DW'(32'hD000_0000 + k);
         pv = ev;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; start_sel = 2'b11; sync_pin = 0; sw_start = 0; sw_stop = 0;
      din = '0; set_holds(1, 21, 41, 61, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(run == '0, "R1 run", 64'(run), 0);
      chk(req == '0, "R1 req", 64'(req), 0);
      chk(valid == '0, "R1 valid", 64'(valid), 0);
      chk(collide == 1'b0, "R1 collide", 64'(collide), 0);
   endtask

   task automatic t_stagger();
      set_holds(1, 21, 41, 61, 0);
      fire_sw(0);
      window(250, "R3 R5 stagger", -1);
      chk(collide == 1'b0, "R5 no collide", 64'(collide), 0);
   endtask

   task automatic t_sources();
      // R2: software strobe ignored when masked
      start_sel = 2'b01;
      sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;
      fire_sw(0);
      repeat (100) @(negedge clk);
      chk(run == '0, "R2 masked sw run", 64'(run), 0);
      // R2: pin held high for several clocks gives one start
      set_holds(1, 21, 41, 61, 0);
      sync_pin = 1'b1;
      @(negedge clk);
      window(200, "R2 pin edge", 6);
      start_sel = 2'b11;
   endtask

   task automatic t_cascade();
      set_holds(0, 20, 40, 60, 1);
      fire_sw(0);
      window(180, "R4 cascade", -1);
      set_holds(1, 21, 41, 61, 0);
   endtask

   task automatic t_restart();
      fire_sw(0);
      repeat (30) @(negedge clk);
      chk(run == 4'b0011, "R6 pre-restart run", 64'(run), 64'(4'b0011));
      fire_sw(0);
      chk(run == '0, "R6 cleared", 64'(run), 0);
      window(170, "R6 restart", -1);
   endtask

   task automatic t_stop();
      fire_sw(1);
      for (int k = 0; k < 200; k++) begin
         if (k > 0) @(negedge clk);
         chk(req == '0 && run == '0, "R7 stop wins", 64'({run, req}), 0);
      end
   endtask

   task automatic t_collide();
      logic [DW-1:0] d0;
      set_holds(5, 5, 41, 61, 0);
      fire_sw(0);
      d0 = cdata[0 +: DW];
      chk(collide == 1'b0, "R9 cleared by start", 64'(collide), 0);
      repeat (5) @(negedge clk);
      chk(req == 4'b0011, "R9 double req", 64'(req), 64'(4'b0011));
      @(negedge clk);
      chk(valid == '0, "R9 no delivery", 64'(valid), 0);
      chk(collide == 1'b1, "R9 flag", 64'(collide), 1);
      chk(cdata[0 +: DW] == d0, "R9 data kept", 64'(cdata[0 +: DW]), 64'(d0));
      repeat (60) @(negedge clk);
      chk(collide == 1'b1, "R9 sticky", 64'(collide), 1);
      sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;
      set_holds(1, 21, 41, 61, 0);
      fire_sw(0);
      chk(collide == 1'b0, "R9 clear on start", 64'(collide), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_stagger();
      t_sources();
      t_cascade();
      t_restart();
      t_stop();
      t_collide();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule